// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This engine feeds a transmit MAC from a circular chain of descriptors held in system memory. Each descriptor occupies four 32-bit words on a 16-byte boundary. Word 0 carries the frame options and the ownership flag, word 1 the buffer pointer, word 2 the frame length (and later the completion status), and word 3 the address of the following descriptor. Software builds the ring, points the engine at its first entry and sets the transmit-on bit. The engine then fetches descriptors one by one over a single-outstanding memory master port. For every descriptor it owns, it passes the buffer pointer, length and option bits to the MAC across a request/done handshake.

When the MAC reports the outcome, the engine writes a packed status word back into word 2. Its last write for that descriptor returns ownership to software by clearing bit 31 of word 0. It then moves on through the next-descriptor pointer. If it reads a descriptor that software still owns, it stops, flags descriptor-unavailable in its status register and stays idle until software writes the resume register.

Top module: `txr_engine`

## Requirements
- R1: After reset the command, list-pointer and status registers read zero, and memReq, macReq and txIrq are low.
- R2: Word k of the current descriptor is fetched at list pointer + 4k, in the order word 0, 1, 2, 3. A write to the list-pointer register (regSel 1) drops address bits [3:0], so the pointer always reads back 16-byte aligned.
- R3: For an engine-owned descriptor (word 0 bit 31 = 1), the MAC receives the following until macDone: word 1 whole on macBufPtr, word 2 bits [15:0] on macLen, word 0 bit 0 on macPad and word 0 bit 1 on macCrc. macReq stays high and these values stay stable for that whole time.
- R4: On macDone the engine writes word 2 as {macResult[15:1], 1, length[15:0]}. Its last write for the descriptor is word 0 with bit 31 cleared and all other bits unchanged.
- R5: After a frame the engine takes the word-3 pointer as its new current descriptor, and regSel 1 reads that pointer back. The ring wraps through the last descriptor's pointer.
- R6: A descriptor with word 0 bit 31 = 0 stops the engine and sets status bit 23 (descriptor unavailable). The engine makes no further memory or MAC requests until a write of any value to the resume register (regSel 2). It then fetches word 0 of the same descriptor again.
- R7: Descriptors are processed only while command bit 8 (transmit on, regSel 0) is set. With it clear, no memory request is issued.
- R8: Status register (regSel 3) bit 16 is set at the end of every frame. Bit 18 is set only when macResult bit 3 (status-word bit 19, complete) is 1. Writing a 1 to bit 16, 18 or 23 clears that bit.
- R9: txIrq pulses for exactly one cycle at the end of a frame whose word 0 bit 2 is set, and never for a frame whose bit 2 is clear.
- R10: memReq and memAddr stay stable until memGnt. After a granted read, no new request is made until memRvalid returns the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 command, 1 list pointer, 2 resume, 3 status |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for regSel |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory access is a write |
| memAddr | output | 32 | Memory byte address |
| memWdata | output | 32 | Memory write data |
| memGnt | input | 1 | Memory accepts the request |
| memRvalid | input | 1 | Read data valid |
| memRdata | input | 32 | Read data |
| macReq | output | 1 | Frame handed to the MAC |
| macBufPtr | output | 32 | Frame buffer pointer with byte offset |
| macLen | output | 16 | Frame length in bytes |
| macPad | output | 1 | Pad short frame |
| macCrc | output | 1 | Append CRC |
| macDone | input | 1 | MAC finished the frame |
| macResult | input | 16 | MAC result, lands in status-word bits [31:16] |
| txIrq | output | 1 | Per-frame interrupt pulse |

## Verification
A ring of four descriptors is run from a vector table. The entries differ in length, in buffer byte offset, in the pad, CRC and interrupt options, and in MAC result codes with and without the completion flag. This separates the fields that are passed to the MAC from those written back, and it shows which frames may raise the interrupt and the complete bit. After the ring wraps onto its first, now software-owned, entry, the halt and descriptor-unavailable path is covered. Directed cases follow. A resume that still finds a software-owned entry must cause exactly one extra read. A resume after ownership is restored must send exactly one frame. A halt while transmit-on is clear must stay silent. A slow-grant memory must give the same results, and list-pointer alignment is checked separately.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int DESC_W     = 32;
  localparam int LEN_W      = 16;
  localparam int RES_W      = 16;
  localparam int SEL_W      = 2;
  localparam int OWNER_BIT  = 31;
  localparam int OPT_PAD    = 0;
  localparam int OPT_CRC    = 1;
  localparam int OPT_INT    = 2;
  localparam int CMD_TXON   = 8;
  localparam int ST_FRAME   = 16;
  localparam int ST_DONE    = 18;
  localparam int ST_NODESC  = 23;
  localparam logic [SEL_W-1:0] SEL_CMD    = 2'd0;
  localparam logic [SEL_W-1:0] SEL_LIST   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_RESUME = 2'd2;
  localparam logic [SEL_W-1:0] SEL_STAT   = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_RD0, S_RD1, S_RD2, S_RD3, S_MAC, S_WRS, S_WRO, S_ADV
  } txrState_e;

  typedef struct packed {
    logic       ldOpt;
    logic       ldBuf;
    logic       ldLen;
    logic       ldNext;
    logic       ldRes;
    logic       advance;
    logic       markHalt;
    logic       frameEnd;
    logic [1:0] wordSel;
  } txrStrobe_t;
endpackage

// File: rtl/txr_ctrl.sv
module txr_ctrl
  import txr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txOn,
  input  logic       halted,
  input  logic       ownerBit,
  input  logic       memGnt,
  input  logic       memRvalid,
  input  logic       macDone,
  output logic       memReq,
  output logic       memWe,
  output logic       macReq,
  output txrStrobe_t stb
);
  txrState_e state, nxt;
  logic waitData;

  always_comb begin
    stb    = '0;
    memReq = 1'b0;
    memWe  = 1'b0;
    macReq = 1'b0;
    nxt    = state;
    unique case (state)
      S_IDLE: if (txOn && !halted) nxt = S_RD0;
      S_RD0: begin
        stb.wordSel = 2'd0;
        memReq = !waitData;
        if (waitData && memRvalid) begin
          if (ownerBit) begin
            stb.ldOpt = 1'b1;
            nxt = S_RD1;
          end else begin
            stb.markHalt = 1'b1;
            nxt = S_IDLE;
          end
        end
      end
      S_RD1: begin
        stb.wordSel = 2'd1;
        memReq = !waitData;
        if (waitData && memRvalid) begin
          stb.ldBuf = 1'b1;
          nxt = S_RD2;
        end
      end
      S_RD2: begin
        stb.wordSel = 2'd2;
        memReq = !waitData;
        if (waitData && memRvalid) begin
          stb.ldLen = 1'b1;
          nxt = S_RD3;
        end
      end
      S_RD3: begin
        stb.wordSel = 2'd3;
        memReq = !waitData;
        if (waitData && memRvalid) begin
          stb.ldNext = 1'b1;
          nxt = S_MAC;
        end
      end
      S_MAC: begin
        macReq = 1'b1;
        if (macDone) begin
          stb.ldRes = 1'b1;
          nxt = S_WRS;
        end
      end
      S_WRS: begin
        stb.wordSel = 2'd2;
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memGnt) nxt = S_WRO;
      end
      S_WRO: begin
        stb.wordSel = 2'd0;
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memGnt) nxt = S_ADV;
      end
      S_ADV: begin
        stb.advance  = 1'b1;
        stb.frameEnd = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      waitData <= 1'b0;
    end else begin
      state <= nxt;
      if (memReq && memGnt && !memWe) waitData <= 1'b1;
      else if (memRvalid) waitData <= 1'b0;
    end
  end
endmodule

// File: rtl/txr_dpath.sv
module txr_dpath
  import txr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  txrStrobe_t        stb,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DESC_W-1:0] regWdata,
  output logic [DESC_W-1:0] regRdata,
  input  logic [DESC_W-1:0] memRdata,
  input  logic [RES_W-1:0]  macResult,
  output logic [AW-1:0]     memAddr,
  output logic [DESC_W-1:0] memWdata,
  output logic [DESC_W-1:0] macBufPtr,
  output logic [LEN_W-1:0]  macLen,
  output logic              macPad,
  output logic              macCrc,
  output logic              txIrq,
  output logic              txOn,
  output logic              halted,
  output logic [DESC_W-1:0] statVal
);
  localparam int PW = AW - 4;

  logic [PW-1:0]     curPtr, nextPtr;
  logic [DESC_W-1:0] optWord, bufPtr;
  logic [LEN_W-1:0]  lenWord;
  logic [RES_W-1:0]  resWord;
  logic              stFrame, stDone, stNoDesc;
  logic              wrCmd, wrList, wrResume, wrStat;
  logic              unusedBits;

  assign wrCmd    = regWe && (regSel == SEL_CMD);
  assign wrList   = regWe && (regSel == SEL_LIST);
  assign wrResume = regWe && (regSel == SEL_RESUME);
  assign wrStat   = regWe && (regSel == SEL_STAT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txOn     <= 1'b0;
      curPtr   <= '0;
      nextPtr  <= '0;
      optWord  <= '0;
      bufPtr   <= '0;
      lenWord  <= '0;
      resWord  <= '0;
      halted   <= 1'b0;
      stFrame  <= 1'b0;
      stDone   <= 1'b0;
      stNoDesc <= 1'b0;
      txIrq    <= 1'b0;
    end else begin
      if (wrCmd) txOn <= regWdata[CMD_TXON];
      if (stb.advance) curPtr <= nextPtr;
      else if (wrList) curPtr <= regWdata[AW-1:4];
      if (stb.ldOpt)  optWord <= memRdata;
      if (stb.ldBuf)  bufPtr  <= memRdata;
      if (stb.ldLen)  lenWord <= memRdata[LEN_W-1:0];
      if (stb.ldNext) nextPtr <= memRdata[AW-1:4];
      if (stb.ldRes)  resWord <= macResult;
      if (wrResume) halted <= 1'b0;
      else if (stb.markHalt) halted <= 1'b1;
      // write-one-to-clear first, hardware set takes precedence
      if (wrStat && regWdata[ST_FRAME])  stFrame  <= 1'b0;
      if (wrStat && regWdata[ST_DONE])   stDone   <= 1'b0;
      if (wrStat && regWdata[ST_NODESC]) stNoDesc <= 1'b0;
      if (stb.frameEnd) stFrame <= 1'b1;
      if (stb.frameEnd && resWord[ST_DONE+1-LEN_W]) stDone <= 1'b1;
      if (stb.markHalt) stNoDesc <= 1'b1;
      txIrq <= stb.frameEnd && optWord[OPT_INT];
    end
  end

  always_comb begin
    statVal = '0;
    statVal[ST_FRAME]  = stFrame;
    statVal[ST_DONE]   = stDone;
    statVal[ST_NODESC] = stNoDesc;
  end

  always_comb begin
    regRdata = '0;
    unique case (regSel)
      SEL_CMD:  regRdata[CMD_TXON] = txOn;
      SEL_LIST: regRdata[AW-1:0] = {curPtr, 4'b0000};
      SEL_STAT: regRdata = statVal;
      default:  regRdata = '0;
    endcase
  end

  assign memAddr  = {curPtr, stb.wordSel, 2'b00};
  assign memWdata = (stb.wordSel == 2'd2) ? {resWord[RES_W-1:1], 1'b1, lenWord}
                                          : {1'b0, optWord[OWNER_BIT-1:0]};
  assign macBufPtr = bufPtr;
  assign macLen    = lenWord;
  assign macPad    = optWord[OPT_PAD];
  assign macCrc    = optWord[OPT_CRC];

  assign unusedBits = ^{resWord[0], optWord[OWNER_BIT], regWdata};
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DESC_W-1:0] regWdata,
  output logic [DESC_W-1:0] regRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [DESC_W-1:0] memWdata,
  input  logic              memGnt,
  input  logic              memRvalid,
  input  logic [DESC_W-1:0] memRdata,
  output logic              macReq,
  output logic [DESC_W-1:0] macBufPtr,
  output logic [LEN_W-1:0]  macLen,
  output logic              macPad,
  output logic              macCrc,
  input  logic              macDone,
  input  logic [RES_W-1:0]  macResult,
  output logic              txIrq
);
  txrStrobe_t        stb;
  logic              txOn;
  logic              halted;
  logic [DESC_W-1:0] statVal;

  txr_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .txOn     (txOn),
    .halted   (halted),
    .ownerBit (memRdata[OWNER_BIT]),
    .memGnt   (memGnt),
    .memRvalid(memRvalid),
    .macDone  (macDone),
    .memReq   (memReq),
    .memWe    (memWe),
    .macReq   (macReq),
    .stb      (stb)
  );

  txr_dpath #(.AW(AW)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .regWe    (regWe),
    .regSel   (regSel),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .memRdata (memRdata),
    .macResult(macResult),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .macBufPtr(macBufPtr),
    .macLen   (macLen),
    .macPad   (macPad),
    .macCrc   (macCrc),
    .txIrq    (txIrq),
    .txOn     (txOn),
    .halted   (halted),
    .statVal  (statVal)
  );
endmodule

// File: rtl/txr_chk.sv
module txr_chk
  import txr_pkg::*;
#(
  parameter int AW = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memWe,
  input logic              memGnt,
  input logic [AW-1:0]     memAddr,
  input logic [DESC_W-1:0] memWdata,
  input logic              macReq,
  input logic              macDone,
  input logic [LEN_W-1:0]  macLen,
  input logic              txIrq,
  input logic              halted,
  input logic [DESC_W-1:0] statVal
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWe)); // R10

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memGnt && !memWe |=> !memReq); // R10

  AST_MAC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    macReq && !macDone |=> macReq && $stable(macLen)); // R3

  AST_OWNER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memAddr[3:2] == 2'd0 |-> !memWdata[OWNER_BIT]); // R4

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memReq && !macReq); // R6

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq); // R9

  AST_IRQ_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> statVal[ST_FRAME]); // R8

  AST_BUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && macReq)); // R3
endmodule

bind txr_engine txr_chk #(.AW(AW)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .memReq  (memReq),
  .memWe   (memWe),
  .memGnt  (memGnt),
  .memAddr (memAddr),
  .memWdata(memWdata),
  .macReq  (macReq),
  .macDone (macDone),
  .macLen  (macLen),
  .txIrq   (txIrq),
  .halted  (halted),
  .statVal (statVal)
);

// File: tb/tb_txr_engine.sv
`timescale 1ns/1ps
module tb_txr_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [1:0]  regSel = 2'd3;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        memReq, memWe;
  logic [31:0] memAddr, memWdata;
  logic        memGnt, memRvalid;
  logic [31:0] memRdata;
  logic        macReq, macPad, macCrc;
  logic [31:0] macBufPtr;
  logic [15:0] macLen;
  logic        macDone;
  logic [15:0] macResult;
  logic        txIrq;

  always #4 clk = ~clk;

  txr_engine dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .regRdata(regRdata), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memGnt(memGnt), .memRvalid(memRvalid), .memRdata(memRdata),
    .macReq(macReq), .macBufPtr(macBufPtr), .macLen(macLen), .macPad(macPad),
    .macCrc(macCrc), .macDone(macDone), .macResult(macResult), .txIrq(txIrq)
  );

  // frame vectors: length, option bits {int,crc,pad}, MAC result, expected word 2
  localparam logic [15:0] lenTab [4] = '{16'h0040, 16'h05EE, 16'h003C, 16'h0100};
  localparam logic [2:0]  optTab [4] = '{3'b111, 3'b011, 3'b100, 3'b001};
  localparam logic [15:0] resTab [4] = '{16'h0008, 16'h100A, 16'h0040, 16'h0028};
  localparam logic [31:0] expW2  [4] = '{32'h0009_0040, 32'h100B_05EE, 32'h0041_003C, 32'h0029_0100};

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [64];
  int          memLat = 1;
  int          latCnt = 0;
  int          rdCnt = 0;
  int          wrCnt = 0;
  logic [7:0]  wrLog [64];

  always @(posedge clk) begin
    if (!rstN) begin
      memGnt <= 1'b0; memRvalid <= 1'b0; memRdata <= '0; latCnt <= 0;
    end else begin
      memRvalid <= 1'b0;
      if (memReq && memGnt) begin
        memGnt <= 1'b0;
        latCnt <= 0;
        if (memWe) begin
          mem[memAddr[7:2]] <= memWdata;
          wrLog[wrCnt[5:0]] <= memAddr[7:0];
          wrCnt <= wrCnt + 1;
        end else begin
          memRdata  <= mem[memAddr[7:2]];
          memRvalid <= 1'b1;
          rdCnt <= rdCnt + 1;
        end
      end else if (memReq) begin
        if (latCnt >= memLat) memGnt <= 1'b1;
        else latCnt <= latCnt + 1;
      end
    end
  end

  // MAC stub
  int          frameIdx = 0;
  int          macCnt = 0;
  logic [31:0] capBuf [16];
  logic [15:0] capLen [16];
  logic        capPad [16];
  logic        capCrc [16];
  int          irqCnt = 0;
  int          irqLong = 0;
  logic        irqPrev = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      macDone <= 1'b0; macResult <= '0; macCnt <= 0;
    end else if (macReq && !macDone) begin
      if (macCnt == 0) begin
        capBuf[frameIdx[3:0]] <= macBufPtr;
        capLen[frameIdx[3:0]] <= macLen;
        capPad[frameIdx[3:0]] <= macPad;
        capCrc[frameIdx[3:0]] <= macCrc;
      end
      if (macCnt == 3) begin
        macDone   <= 1'b1;
        macResult <= resTab[frameIdx % 4];
        macCnt    <= 0;
        frameIdx  <= frameIdx + 1;
      end else macCnt <= macCnt + 1;
    end else macDone <= 1'b0;
    if (rstN) begin
      if (txIrq) irqCnt <= irqCnt + 1;
      if (txIrq && irqPrev) irqLong <= irqLong + 1;
      irqPrev <= txIrq;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    regSel = sel; regWdata = val; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regSel = 2'd3;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    regSel = sel;
    #1 val = regRdata;
    regSel = 2'd3;
  endtask

  task automatic setDesc(input int k, input bit own);
    mem[k*4]   = {own, 15'h0, 8'(k + 8'hA0), 5'h0, optTab[k]};
    mem[k*4+1] = 32'h2000_0000 | (k << 12) | k;
    mem[k*4+2] = {16'h0, lenTab[k]};
    mem[k*4+3] = ((k + 1) % 4) * 16;
  endtask

  task automatic waitHalt();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (regRdata[23]) break;
    end
  endtask

  initial begin
    logic [31:0] v;
    int r0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk("R1 status", regRdata, 32'h0);
    chk("R1 memReq", {31'b0, memReq}, 32'h0);
    chk("R1 macReq", {31'b0, macReq}, 32'h0);
    chk("R1 txIrq", {31'b0, txIrq}, 32'h0);
    regRead(2'd0, v); chk("R1 command", v, 32'h0);
    regRead(2'd1, v); chk("R1 list pointer", v, 32'h0);

    // table-driven ring pass
    for (int k = 0; k < 4; k++) setDesc(k, 1'b1);
    regWrite(2'd1, 32'h0000_0000);
    regWrite(2'd0, 32'h0000_0100);
    waitHalt();
    chk("R3 frame count", frameIdx, 32'd4);
    for (int k = 0; k < 4; k++) begin
      chk("R3 buffer pointer", capBuf[k], 32'h2000_0000 | (k << 12) | k);
      chk("R3 length", {16'h0, capLen[k]}, {16'h0, lenTab[k]});
      chk("R3 pad", {31'b0, capPad[k]}, {31'b0, optTab[k][0]});
      chk("R3 crc", {31'b0, capCrc[k]}, {31'b0, optTab[k][1]});
      chk("R4 status word", mem[k*4+2], expW2[k]);
      chk("R4 owner released", mem[k*4], {16'h0, 8'(k + 8'hA0), 5'h0, optTab[k]});
      chk("R4 write order status", {24'h0, wrLog[2*k]}, k*16 + 8);
      chk("R4 write order owner last", {24'h0, wrLog[2*k+1]}, k*16);
    end
    chk("R2 reads per pass", rdCnt, 32'd17);
    chk("R9 irq pulses", irqCnt, 32'd2);
    chk("R9 irq width", irqLong, 32'd0);
    regRead(2'd3, v); chk("R8 R6 status after ring", v, 32'h0085_0000);
    regRead(2'd1, v); chk("R5 pointer wrapped", v, 32'h0);
    r0 = rdCnt;
    repeat (20) @(negedge clk);
    chk("R6 quiet while halted", rdCnt, r0);

    // R8 write-one-to-clear
    regWrite(2'd3, 32'h0005_0000);
    regRead(2'd3, v); chk("R8 clear frame bits", v, 32'h0080_0000);
    regWrite(2'd3, 32'h0080_0000);
    regRead(2'd3, v); chk("R8 clear unavailable", v, 32'h0);

    // R6 resume onto a still software-owned descriptor
    r0 = rdCnt;
    regWrite(2'd2, 32'h0);
    waitHalt();
    repeat (5) @(negedge clk);
    chk("R6 single re-read", rdCnt, r0 + 1);
    chk("R6 no frame sent", frameIdx, 32'd4);

    // R6 resume after ownership restored: one frame, then halt on next
    setDesc(0, 1'b1);
    regWrite(2'd3, 32'h0085_0000);
    regWrite(2'd2, 32'h0);
    waitHalt();
    chk("R6 one frame after resume", frameIdx, 32'd5);
    chk("R4 status rewritten", mem[2], expW2[0]);
    regRead(2'd1, v); chk("R5 next pointer", v, 32'h10);
    regRead(2'd3, v); chk("R8 status after resume", v, 32'h0085_0000);

    // R7 transmit-on gating, with slow grants for R10
    regWrite(2'd0, 32'h0);
    regWrite(2'd3, 32'h0085_0000);
    setDesc(1, 1'b1);
    regWrite(2'd2, 32'h0);
    r0 = rdCnt;
    repeat (40) @(negedge clk);
    chk("R7 no reads while off", rdCnt, r0);
    chk("R7 no frame while off", frameIdx, 32'd5);
    memLat = 3;
    regWrite(2'd0, 32'h0000_0100);
    waitHalt();
    chk("R7 frame after enable", frameIdx, 32'd6);
    chk("R10 slow grant status", mem[6], expW2[1]);
    chk("R10 slow grant owner", mem[4], {16'h0, 8'hA1, 5'h0, optTab[1]});
    regRead(2'd1, v); chk("R5 pointer after slow frame", v, 32'h20);

    // R2 alignment of list pointer
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, 32'h0000_0037);
    regRead(2'd1, v); chk("R2 aligned pointer", v, 32'h30);
    regRead(2'd0, v); chk("R7 command readback", v, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule